// File: doc/BRIEF.md
# Serial-Bus Byte Memory Target

This block is a synthesizable target for a two-wire serial bus that presents itself as a byte-wide memory. It oversamples the clock and data lines on the system clock. It finds the framing conditions on the bus: a Start, a repeated Start and a Stop. It answers only to its own device select byte. That byte is the fixed type nibble `1010`, then three chip-address bits that must equal the strap inputs, then the direction bit, with 1 meaning read.

One internal address counter is kept across transactions and serves every kind of access. A write transaction loads the counter from two address bytes, high byte first. The data bytes that follow are stored at the counter, and each stored byte advances it. A read transaction returns the byte at the counter and then advances it. With this scheme the bus master can do three kinds of read:
- a current-address read, which needs no address phase;
- a random read, which is a write that carries only the address, followed by a repeated Start and a read;
- a sequential read, which goes on for as long as the master acknowledges each byte.

The counter wraps from the top address back to zero. When the master does not acknowledge a byte, the target drops into standby.

The slave side of the data line is open drain, driven through an output-enable. The memory depth is a parameter. The full part uses 15 address bits; the default is smaller so that the array stays small. Address bits above the parameter width are ignored.

Top module: `i2cee_slave`

## Requirements
- R1: Under reset and right after it, `sdaOe` is 0 and the address counter is 0, so the first current-address read after a reset returns the byte at address 0.
- R2: The target acknowledges a device select byte (drives `sdaOe`=1 in its 9th clock) only when bits 7..4 are `1010` and bits 3..1 equal `chipSel`. On a mismatch it does not acknowledge, and it ignores the bus until the next Start.
- R3: In a write transaction, the two bytes after the device select are the address, high byte first, and each is acknowledged. Address bits at and above `ADDR_W` are ignored.
- R4: With `wrCtl` low, every data byte after the address is acknowledged and stored at the counter, and the counter then advances by one.
- R5: With `wrCtl` high, data bytes are not acknowledged and memory is left unchanged.
- R6: After an address-only write, a repeated Start and a read device select, the target returns the byte at the loaded address.
- R7: A read that starts without an address phase returns the byte at the counter. The counter then advances, so the next such read returns the following address.
- R8: While the master acknowledges each byte, the target sends bytes from consecutive addresses.
- R9: The counter wraps from address 2^ADDR_W-1 to 0, both for reads and for writes.
- R10: When the master leaves SDA high in the 9th clock of a read byte, the target releases SDA and stays off the bus until the next Start. The counter has still advanced past that byte.
- R11: Reads behave the same whatever the level of `wrCtl`.
- R12: `sdaOe` changes only while SCL is low.
- R13: A Start or a Stop in the middle of a byte abandons that byte. The counter is unchanged and the new transaction is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| chipSel | input | 3 | Strap value matched against device select bits 3..1 |
| wrCtl | input | 1 | Write inhibit; high blocks the storing of data bytes |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
Two functions can land on the same byte boundary: the counter advance from the byte just sent, and the fetch of the next byte to send. At the 9th rising edge of a read byte the target takes the master's acknowledge and advances the counter. At the falling edge that follows, it must already present the byte from the new address. Sequential reads across the wrap point provoke this with the tightest margin, and back-to-back current-address reads provoke it across transactions. A scoreboard judges the result by comparing every returned byte against a bench-side memory model and counter.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

  // Control-to-datapath strobes; at most one of the four strobes is set per cycle.
  typedef struct packed {
    logic       loadHi;
    logic       loadLo;
    logic       wrByte;
    logic       incAddr;
    logic [7:0] rxByte;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AH,
    ST_AL,
    ST_WR,
    ST_RD
  } busState_t;

endpackage

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
  import i2cee_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic       wrCtl,
  input  logic [7:0] rdData,
  output ctlStrobe_t stb,
  output logic       sdaOe
);

  localparam logic [3:0] BIT_LAST = 4'd8;

  logic [1:0] sclS, sdaS;
  logic       sclPrev, sdaPrev;
  logic       sclRise, sclFall, startDet, stopDet;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shreg;
  logic [7:0] txByte;
  logic       ackPhase;
  logic       rdMode;

  // Two-flop synchronizers plus a previous-value stage for edge detection.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclS    <= 2'b11;
      sdaS    <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclS    <= {sclS[0], sclIn};
      sdaS    <= {sdaS[0], sdaIn};
      sclPrev <= sclS[1];
      sdaPrev <= sdaS[1];
    end
  end

  assign sclRise  =  sclS[1] & ~sclPrev;
  assign sclFall  = ~sclS[1] &  sclPrev;
  assign startDet =  sclS[1] &  sclPrev &  sdaPrev & ~sdaS[1];
  assign stopDet  =  sclS[1] &  sclPrev & ~sdaPrev &  sdaS[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shreg    <= '0;
      txByte   <= '0;
      ackPhase <= 1'b0;
      rdMode   <= 1'b0;
      sdaOe    <= 1'b0;
      stb      <= '0;
    end else begin
      stb <= '0;
      if (startDet || stopDet) begin
        state    <= startDet ? ST_DEV : ST_IDLE;
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        sdaOe    <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: ;
          ST_RD: begin
            if (!ackPhase) begin
              if (sclRise) bitCnt <= bitCnt + 4'd1;
              else if (sclFall) begin
                if (bitCnt == BIT_LAST) begin
                  sdaOe    <= 1'b0;
                  ackPhase <= 1'b1;
                end else begin
                  sdaOe  <= ~txByte[7];
                  txByte <= {txByte[6:0], 1'b0};
                end
              end
            end else if (sclRise) begin
              stb.incAddr <= 1'b1;
              if (sdaS[1]) begin
                state    <= ST_IDLE;
                ackPhase <= 1'b0;
              end
            end else if (sclFall) begin
              ackPhase <= 1'b0;
              bitCnt   <= '0;
              sdaOe    <= ~rdData[7];
              txByte   <= {rdData[6:0], 1'b0};
            end
          end
          default: begin
            if (sclRise && !ackPhase) begin
              shreg  <= {shreg[6:0], sdaS[1]};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && !ackPhase && bitCnt == BIT_LAST) begin
              ackPhase <= 1'b1;
              case (state)
                ST_DEV:
                  if (shreg[7:4] == DEV_TYPE && shreg[3:1] == chipSel) begin
                    sdaOe  <= 1'b1;
                    rdMode <= shreg[0];
                  end else state <= ST_IDLE;
                ST_AH: begin
                  sdaOe      <= 1'b1;
                  stb.loadHi <= 1'b1;
                  stb.rxByte <= shreg;
                end
                ST_AL: begin
                  sdaOe      <= 1'b1;
                  stb.loadLo <= 1'b1;
                  stb.rxByte <= shreg;
                end
                default:
                  if (!wrCtl) begin
                    sdaOe      <= 1'b1;
                    stb.wrByte <= 1'b1;
                    stb.rxByte <= shreg;
                  end else state <= ST_IDLE;
              endcase
            end else if (sclFall && ackPhase) begin
              ackPhase <= 1'b0;
              bitCnt   <= '0;
              sdaOe    <= 1'b0;
              case (state)
                ST_DEV:
                  if (rdMode) begin
                    state  <= ST_RD;
                    sdaOe  <= ~rdData[7];
                    txByte <= {rdData[6:0], 1'b0};
                  end else state <= ST_AH;
                ST_AH:   state <= ST_AL;
                ST_AL:   state <= ST_WR;
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end

  // R12
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS[1]);

  // R10
  nack_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD && ackPhase && sclRise && sdaS[1]) |=> (state == ST_IDLE && !sdaOe));

  // R5
  wc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrByte |-> $past(!wrCtl));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadHi, stb.loadLo, stb.wrByte, stb.incAddr}));

endmodule

// File: rtl/i2cee_datapath.sv
module i2cee_datapath
  import i2cee_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t stb,
  output logic [7:0] rdData
);

  localparam int HI_W  = ADDR_W - 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ONE  = 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] addrCnt;
  logic [HI_W-1:0]   hiPart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt <= '0;
      hiPart  <= '0;
    end else if (stb.loadHi) begin
      hiPart <= stb.rxByte[HI_W-1:0];
    end else if (stb.loadLo) begin
      addrCnt <= {hiPart, stb.rxByte};
    end else if (stb.wrByte || stb.incAddr) begin
      addrCnt <= addrCnt + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrByte) mem[addrCnt] <= stb.rxByte;
  end

  assign rdData = mem[addrCnt];

  // R9
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.incAddr || stb.wrByte) && addrCnt == LAST) |=> addrCnt == '0);

endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
  import i2cee_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic       wrCtl,
  output logic       sdaOe
);

  ctlStrobe_t stb;
  logic [7:0] rdData;

  i2cee_ctrl #(.DEV_TYPE(DEV_TYPE)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .chipSel(chipSel), .wrCtl(wrCtl), .rdData(rdData),
    .stb(stb), .sdaOe(sdaOe)
  );

  i2cee_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(rdData)
  );

endmodule

// File: tb/i2cee_slave_tb_top.sv
module i2cee_slave_tb_top;

  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int Q      = 8;
  localparam logic [2:0] CHIP = 3'b101;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1, wrCtl = 1'b0;
  logic [2:0] chipSel = CHIP;
  logic sdaOe, sdaLine;
  assign sdaLine = sdaM & ~sdaOe;

  always #5 clk = ~clk;

  i2cee_slave #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .chipSel(chipSel), .wrCtl(wrCtl), .sdaOe(sdaOe)
  );

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t      expQ[$];
  logic [7:0] gotQ[$];
  logic [7:0] model [DEPTH];
  int total = 0, bad = 0, r12Bad = 0, ctr = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: pairs each returned byte with the expected one.
  item_t      eItem;
  logic [7:0] gByte;
  always @(negedge clk) begin
    if (gotQ.size() > 0 && expQ.size() > 0) begin
      eItem = expQ.pop_front();
      gByte = gotQ.pop_front();
      check(gByte === eItem.v, eItem.tag, "read byte", int'(gByte), int'(eItem.v));
    end
  end

  // R12: slave enable must not move while SCL is high.
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && sclM && sdaOe !== prevOe) r12Bad++;
    prevOe <= sdaOe;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic clkBit(input logic b, output logic got);
    sdaM = b; wq();
    sclM = 1'b1; wq();
    got = sdaLine; wq();
    sclM = 1'b0; wq();
  endtask

  task automatic startCond();
    sdaM = 1'b1; wq(); sclM = 1'b1; wq(); sdaM = 1'b0; wq(); sclM = 1'b0; wq();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; wq(); sclM = 1'b1; wq(); sdaM = 1'b1; wq(); wq();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    logic g;
    for (int i = 7; i >= 0; i--) clkBit(b[i], g);
    clkBit(1'b1, g);
    ack = !g;
  endtask

  task automatic readByte(input bit mAck);
    logic [7:0] v;
    logic g;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, g);
      v[i] = g;
    end
    clkBit(mAck ? 1'b0 : 1'b1, g);
    gotQ.push_back(v);
  endtask

  task automatic expectAt(input int a, input string tag);
    item_t it;
    it.v = model[a % DEPTH];
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic setAddr(input logic [15:0] a);
    bit ack;
    startCond();
    sendByte({4'b1010, CHIP, 1'b0}, ack);
    check(ack, "R2", "select ack", ack, 1);
    sendByte(a[15:8], ack);
    check(ack, "R3", "addr high ack", ack, 1);
    sendByte(a[7:0], ack);
    check(ack, "R3", "addr low ack", ack, 1);
  endtask

  task automatic writeSeq(input logic [15:0] a, input int n, input logic [7:0] base);
    bit ack;
    int idx;
    setAddr(a);
    idx = int'(a) % DEPTH;
    for (int i = 0; i < n; i++) begin
      sendByte(base + 8'(i), ack);
      check(ack == !wrCtl, wrCtl ? "R5" : "R4", "data ack", ack, !wrCtl);
      if (!wrCtl) begin
        model[idx] = base + 8'(i);
        idx = (idx + 1) % DEPTH;
      end
    end
    stopCond();
  endtask

  task automatic readTail(input int a, input int n, input string tag);
    bit ack;
    sendByte({4'b1010, CHIP, 1'b1}, ack);
    check(ack, tag, "read select ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      expectAt(a + i, tag);
      readByte(i < n - 1);
    end
    stopCond();
    ctr = (a + n) % DEPTH;
  endtask

  task automatic randRead(input logic [15:0] a, input int n, input string tag);
    setAddr(a);
    startCond();
    readTail(int'(a) % DEPTH, n, tag);
  endtask

  task automatic curRead(input int n, input string tag);
    startCond();
    readTail(ctr, n, tag);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin : main
    bit ack;
    logic g;
    int lowSeen;
    repeat (5) @(negedge clk);
    check(sdaOe == 1'b0, "R1", "oe in reset", sdaOe, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(sdaOe == 1'b0, "R1", "oe after reset", sdaOe, 0);

    // R4: plain write of four bytes
    writeSeq(16'h0010, 4, 8'h11);

    // R2: wrong chip bits, then a byte that must also be ignored
    startCond();
    sendByte({4'b1010, CHIP ^ 3'b001, 1'b0}, ack);
    check(!ack, "R2", "wrong chip ack", ack, 0);
    sendByte(8'h00, ack);
    check(!ack, "R2", "ignored after mismatch", ack, 0);
    stopCond();
    startCond();
    sendByte({4'b1011, CHIP, 1'b1}, ack);
    check(!ack, "R2", "wrong type ack", ack, 0);
    stopCond();

    // R6 R8: random read then sequential stream
    randRead(16'h0010, 4, "R6 R8");

    // R7: two current-address reads follow the counter
    randRead(16'h0011, 1, "R6");
    curRead(1, "R7");
    curRead(1, "R7");

    // R9 R3: write across the top with junk high address bits, read it back
    writeSeq(16'hFFFE, 4, 8'h40);
    randRead(16'h03FE, 4, "R9");

    // R5 R11: write blocked, read still works with wrCtl high
    wrCtl = 1'b1;
    writeSeq(16'h0010, 1, 8'h5A);
    randRead(16'h0010, 1, "R5 R11");
    wrCtl = 1'b0;

    // R10: master nack, then extra clocks must see a released line
    setAddr(16'h0010);
    startCond();
    sendByte({4'b1010, CHIP, 1'b1}, ack);
    check(ack, "R10", "read select ack", ack, 1);
    expectAt(16'h10, "R10");
    readByte(1'b0);
    lowSeen = 0;
    for (int i = 0; i < 9; i++) begin
      clkBit(1'b1, g);
      if (!g) lowSeen++;
    end
    check(lowSeen == 0, "R10", "line low after nack", lowSeen, 0);
    stopCond();
    ctr = 16'h11;
    curRead(1, "R10");

    // R13: Stop mid-address, then Start mid-address
    startCond();
    sendByte({4'b1010, CHIP, 1'b0}, ack);
    for (int i = 0; i < 4; i++) clkBit(1'b0, g);
    stopCond();
    curRead(1, "R13");
    startCond();
    sendByte({4'b1010, CHIP, 1'b0}, ack);
    for (int i = 0; i < 3; i++) clkBit(1'b1, g);
    startCond();
    readTail(ctr, 1, "R13");

    // R1: counter cleared by reset
    @(negedge clk); rstN = 1'b0;
    repeat (4) @(negedge clk); rstN = 1'b1;
    repeat (4) @(negedge clk);
    ctr = 0;
    curRead(1, "R1");

    repeat (20) @(negedge clk);
    check(expQ.size() == 0 && gotQ.size() == 0, "R8", "scoreboard drained",
          expQ.size() + gotQ.size(), 0);
    check(r12Bad == 0, "R12", "oe moved with SCL high", r12Bad, 0);
    finishRun();
  end

endmodule